// File: doc/BRIEF.md
# Unit-to-Register Dependency Matrix

This block tracks, for every function-unit row, which architectural registers the row still has to read and which it will write. Register usage is kept as one wire per register rather than as an encoded index. An issue strobe loads a row with its register profile: up to two sources, one destination and an enable for each. Each source marks a need-read bit and the destination marks a need-write bit. The bits are OR-reduced across all rows into per-register pending-read and pending-write vectors. The issue logic uses these vectors to avoid write-after-write and write-after-read hazards.

Rows are grouped onto shared ALUs, with consecutive rows per ALU. Several rows waiting on one ALU act like reservation stations. A row becomes ready when no other row still owes a write to any of its sources. Within each group, the block offers a go to the lowest-index ready row, provided that ALU is not stalled. The environment answers with a capture strobe once the operands are latched, and later with a write-done strobe once the result is committed. Execution and operand storage happen outside the block.

Top module: `fu_reg_depmatrix`

## Requirements
- R1: After reset, pend_rd, pend_wr, row_busy, row_ready and row_go are all zero.
- R2: An issue on an idle row sets need-read bit k for each enabled source with index k, and need-write bit k for an enabled destination k. pend_rd and pend_wr are the OR of all rows' bits, and they change in the cycle after the issue edge.
- R3: Register index 0 never sets a need-read or need-write bit, so bit 0 of pend_rd and pend_wr stays 0 and register 0 never blocks a reader.
- R4: An issue on a busy row has no effect on that row. A row is busy while it waits for capture, or while it still holds a need-write bit.
- R5: A row is ready when it waits for capture and none of its need-read registers has a need-write bit in another row. The row's own need-write bit does not block it.
- R6: Capture on a row waiting for capture clears its need-read bits and ends the wait. A row without a destination then becomes idle. Capture on a row that is not waiting has no effect.
- R7: Write-done clears a row's need-write bits only after that row has been captured. While the row still waits for capture, write-done is ignored.
- R8: Row r belongs to ALU r / ROWS_PER_ALU. For each ALU whose stall input is low, row_go marks only the lowest-index ready row of its group. A stalled ALU gives no go.
- R9: A row blocked only by another row's pending write becomes ready in the cycle after that row's write-done edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | NUM_ROWS | Per-row issue strobe |
| src_a | input | NUM_ROWS x IDX_W | First source register number per row |
| src_a_en | input | NUM_ROWS | First source used |
| src_b | input | NUM_ROWS x IDX_W | Second source register number per row |
| src_b_en | input | NUM_ROWS | Second source used |
| dst | input | NUM_ROWS x IDX_W | Destination register number per row |
| dst_en | input | NUM_ROWS | Destination used |
| capture | input | NUM_ROWS | Operands latched for that row |
| wr_done | input | NUM_ROWS | Result of that row written |
| alu_stall | input | NUM_ALUS | Per-ALU pipeline stall |
| pend_rd | output | NUM_REGS | Register has a pending reader |
| pend_wr | output | NUM_REGS | Register has a pending writer |
| row_busy | output | NUM_ROWS | Row occupied |
| row_ready | output | NUM_ROWS | Row may hand operands to its ALU |
| row_go | output | NUM_ROWS | Row selected for its ALU this cycle |

## Verification
The bench loads rows with several kinds of register profile:
- disjoint sources and destinations, which separate plain bit setting from hazard handling;
- a source that matches another row's destination, which shows a true read-after-write block;
- a row that reads its own destination, which must not block itself;
- register 0 used as source and destination, which must stay invisible.

Strobes are also sent at the wrong time: issue on a busy row, capture on an idle row, and write-done before capture. These show that each row's state machine ignores out-of-order events. Two rows that are ready together in one ALU group, with the ALU first stalled and then free, tell the lowest-index choice apart from any other choice.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int PICK_W = 64;

  // isolate the lowest set bit of a vector
  function automatic logic [PICK_W-1:0] lowest_set(input logic [PICK_W-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/dm_alu_pick.sv
module dm_alu_pick
  import dm_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ready,
  input  logic         stall,
  output logic [N-1:0] go
);
  logic [PICK_W-1:0] wide_rdy;
  logic [PICK_W-1:0] wide_pick;

  always_comb begin
    wide_rdy = '0;
    wide_rdy[N-1:0] = ready;
    wide_pick = lowest_set(wide_rdy);
    go = stall ? '0 : wide_pick[N-1:0];
  end

  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(go)); // R8
  AST_GO_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n) (go != '0) |-> !stall); // R8
  AST_GO_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n) (go & ~ready) == '0); // R8
endmodule

// File: rtl/dm_row.sv
module dm_row #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [RW-1:0]   src_a,
  input  logic            src_a_en,
  input  logic [RW-1:0]   src_b,
  input  logic            src_b_en,
  input  logic [RW-1:0]   dst,
  input  logic            dst_en,
  input  logic            capture,
  input  logic            wr_done,
  input  logic [NREG-1:0] wr_others,
  output logic [NREG-1:0] need_rd,
  output logic [NREG-1:0] need_wr,
  output logic            armed,
  output logic            busy,
  output logic            ready
);
  // one wire per register; index 0 is never tracked
  function automatic logic [NREG-1:0] reg_bit(input logic [RW-1:0] idx, input logic en);
    logic [NREG-1:0] v;
    v = '0;
    if (en && idx != '0) v[idx] = 1'b1;
    return v;
  endfunction

  logic            armed_q;
  logic [NREG-1:0] rd_q, wr_q;
  logic            accept, cap_hit, wr_hit, conflict;

  assign busy     = armed_q | (|wr_q);
  assign accept   = issue & ~busy;
  assign cap_hit  = capture & armed_q;
  assign wr_hit   = wr_done & ~armed_q & (|wr_q);
  assign conflict = |(rd_q & wr_others);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (accept) begin
      armed_q <= 1'b1;
      rd_q    <= reg_bit(src_a, src_a_en) | reg_bit(src_b, src_b_en);
      wr_q    <= reg_bit(dst, dst_en);
    end else begin
      if (cap_hit) begin
        armed_q <= 1'b0;
        rd_q    <= '0;
      end
      if (wr_hit) wr_q <= '0;
    end
  end

  assign need_rd = rd_q;
  assign need_wr = wr_q;
  assign armed   = armed_q;
  assign ready   = armed_q & ~conflict;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && busy && !capture && !wr_done) |=> ($stable(need_rd) && $stable(need_wr))); // R4
  AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && armed) |=> (need_rd == '0 && !armed)); // R6
  AST_WR_HELD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_done) |=> $stable(need_wr)); // R7
  AST_WR_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !armed && need_wr != '0) |=> (need_wr == '0)); // R7
endmodule

// File: rtl/fu_reg_depmatrix.sv
module fu_reg_depmatrix #(
  parameter int NUM_ROWS     = 4,
  parameter int NUM_REGS     = 32,
  parameter int ROWS_PER_ALU = 2,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int NUM_ALUS    = NUM_ROWS / ROWS_PER_ALU
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_ROWS-1:0]             issue_vld,
  input  logic [NUM_ROWS-1:0][IDX_W-1:0]  src_a,
  input  logic [NUM_ROWS-1:0]             src_a_en,
  input  logic [NUM_ROWS-1:0][IDX_W-1:0]  src_b,
  input  logic [NUM_ROWS-1:0]             src_b_en,
  input  logic [NUM_ROWS-1:0][IDX_W-1:0]  dst,
  input  logic [NUM_ROWS-1:0]             dst_en,
  input  logic [NUM_ROWS-1:0]             capture,
  input  logic [NUM_ROWS-1:0]             wr_done,
  input  logic [NUM_ALUS-1:0]             alu_stall,
  output logic [NUM_REGS-1:0]             pend_rd,
  output logic [NUM_REGS-1:0]             pend_wr,
  output logic [NUM_ROWS-1:0]             row_busy,
  output logic [NUM_ROWS-1:0]             row_ready,
  output logic [NUM_ROWS-1:0]             row_go
);
  logic [NUM_ROWS-1:0][NUM_REGS-1:0] need_rd, need_wr, wr_others;
  logic [NUM_ROWS-1:0]               armed;

  // per-register OR over rows, and per-row OR over the other rows
  always_comb begin
    pend_rd   = '0;
    pend_wr   = '0;
    wr_others = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      pend_rd = pend_rd | need_rd[r];
      pend_wr = pend_wr | need_wr[r];
      for (int j = 0; j < NUM_ROWS; j++)
        if (j != r) wr_others[r] = wr_others[r] | need_wr[j];
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    dm_row #(.NREG(NUM_REGS), .RW(IDX_W)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue_vld[r]),
      .src_a     (src_a[r]),
      .src_a_en  (src_a_en[r]),
      .src_b     (src_b[r]),
      .src_b_en  (src_b_en[r]),
      .dst       (dst[r]),
      .dst_en    (dst_en[r]),
      .capture   (capture[r]),
      .wr_done   (wr_done[r]),
      .wr_others (wr_others[r]),
      .need_rd   (need_rd[r]),
      .need_wr   (need_wr[r]),
      .armed     (armed[r]),
      .busy      (row_busy[r]),
      .ready     (row_ready[r])
    );
  end

  for (genvar a = 0; a < NUM_ALUS; a++) begin : g_alu
    dm_alu_pick #(.N(ROWS_PER_ALU)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (row_ready[a*ROWS_PER_ALU +: ROWS_PER_ALU]),
      .stall (alu_stall[a]),
      .go    (row_go[a*ROWS_PER_ALU +: ROWS_PER_ALU])
    );
  end

  AST_REG0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_rd[0] && !pend_wr[0]); // R3
  AST_READY_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ready[0]) |-> ((need_rd[0] & pend_wr & ~need_wr[0]) == '0)); // R5
endmodule

// File: tb/tb_fu_reg_depmatrix.sv
`timescale 1ns/1ps
module tb_fu_reg_depmatrix;
  localparam int NF = 4, NR = 32, RPA = 2, NA = NF / RPA, IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NF-1:0] issue_vld = '0, src_a_en = '0, src_b_en = '0, dst_en = '0;
  logic [NF-1:0] capture = '0, wr_done = '0;
  logic [NF-1:0][IW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [NA-1:0] alu_stall = '0;
  logic [NR-1:0] pend_rd, pend_wr;
  logic [NF-1:0] row_busy, row_ready, row_go;

  fu_reg_depmatrix #(.NUM_ROWS(NF), .NUM_REGS(NR), .ROWS_PER_ALU(RPA)) dut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .src_a(src_a), .src_a_en(src_a_en),
    .src_b(src_b), .src_b_en(src_b_en), .dst(dst), .dst_en(dst_en), .capture(capture),
    .wr_done(wr_done), .alu_stall(alu_stall), .pend_rd(pend_rd), .pend_wr(pend_wr),
    .row_busy(row_busy), .row_ready(row_ready), .row_go(row_go));

  typedef struct packed {
    logic [NR-1:0] prd, pwr;
    logic [NF-1:0] busy, rdy, go;
  } exp_t;
  exp_t  q_exp[$];
  string q_req[$];
  int errors = 0, checks = 0;

  // bench model
  logic [NR-1:0] mrd [NF];
  logic [NR-1:0] mwr [NF];
  logic          marm[NF];

  function automatic logic [NR-1:0] bitof(input logic [IW-1:0] s, input logic e);
    if (!e || s == 0) return '0;
    return {{(NR-1){1'b0}}, 1'b1} << s;
  endfunction

  task automatic put(input int r, input int a, input bit ae, input int b, input bit be,
                     input int d, input bit de);
    issue_vld[r] = 1'b1;
    src_a[r] = IW'(a); src_a_en[r] = ae;
    src_b[r] = IW'(b); src_b_en[r] = be;
    dst[r] = IW'(d); dst_en[r] = de;
  endtask

  task automatic tick(input string req);
    exp_t e;
    logic pre_arm;
    logic [NR-1:0] others;
    for (int r = 0; r < NF; r++) begin
      pre_arm = marm[r];
      if (issue_vld[r] && !(marm[r] || mwr[r] != 0)) begin
        mrd[r] = bitof(src_a[r], src_a_en[r]) | bitof(src_b[r], src_b_en[r]);
        mwr[r] = bitof(dst[r], dst_en[r]);
        marm[r] = 1'b1;
      end else begin
        if (capture[r] && pre_arm) begin mrd[r] = '0; marm[r] = 1'b0; end
        if (wr_done[r] && !pre_arm) mwr[r] = '0;
      end
    end
    e = '0;
    for (int r = 0; r < NF; r++) begin
      e.prd |= mrd[r];
      e.pwr |= mwr[r];
      e.busy[r] = marm[r] || (mwr[r] != 0);
      others = '0;
      for (int j = 0; j < NF; j++) if (j != r) others |= mwr[j];
      e.rdy[r] = marm[r] && ((mrd[r] & others) == 0);
    end
    for (int a = 0; a < NA; a++) begin
      if (!alu_stall[a]) begin
        for (int k = 0; k < RPA; k++) begin
          if (e.rdy[a*RPA+k]) begin e.go[a*RPA+k] = 1'b1; break; end
        end
      end
    end
    q_exp.push_back(e);
    q_req.push_back(req);
    @(posedge clk);
    @(negedge clk);
    issue_vld = '0; capture = '0; wr_done = '0;
  endtask

  task automatic cmp(input string req, input string what, input logic [NR-1:0] act,
                     input logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares each expected snapshot shortly after its edge
  initial begin
    exp_t e;
    string rq;
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        rq = q_req.pop_front();
        cmp(rq, "pend_rd", pend_rd, e.prd);
        cmp(rq, "pend_wr", pend_wr, e.pwr);
        cmp(rq, "row_busy", NR'(row_busy), NR'(e.busy));
        cmp(rq, "row_ready", NR'(row_ready), NR'(e.rdy));
        cmp(rq, "row_go", NR'(row_go), NR'(e.go));
      end
    end
  end

  bit finished = 0;
  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NF; r++) begin mrd[r] = '0; mwr[r] = '0; marm[r] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1");                                   // reset state
    put(0, 1, 1, 2, 1, 3, 1);                     // R2: r1,r2 -> r3
    tick("R2");
    put(1, 3, 1, 0, 1, 0, 1);                     // R3 R5: reads r3 (blocked), r0 ignored
    put(2, 5, 1, 0, 0, 5, 1);                     // R5: own write of r5 does not block
    tick("R3_R5");
    put(0, 9, 1, 10, 1, 11, 1);                   // R4: row 0 busy
    tick("R4");
    alu_stall = 2'b01;                            // R8: ALU0 stalled
    tick("R8_stall");
    alu_stall = 2'b00;
    capture[0] = 1'b1;                            // R6: row 0 captured, keeps r3
    wr_done[2] = 1'b1;                            // R7: row 2 still armed, ignored
    tick("R6_R7");
    wr_done[0] = 1'b1;                            // R9: r3 freed
    tick("R9");
    put(3, 7, 1, 0, 0, 8, 1);                     // R8: rows 2 and 3 ready, lowest wins
    tick("R8_lowest");
    capture[2] = 1'b1;                            // R8: row 3 now selected
    capture[0] = 1'b1;                            // R6: row 0 not armed, ignored
    tick("R8_R6");
    capture[1] = 1'b1;                            // R6: no destination -> idle
    wr_done[2] = 1'b1;                            // R7: after capture, cleared
    tick("R6_R7_done");
    put(1, 8, 1, 0, 0, 0, 0);                     // R5: reads r8 owed by row 3
    capture[3] = 1'b1;
    tick("R5_block");
    wr_done[3] = 1'b1;                            // R9: row 1 unblocked
    tick("R9_next");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule